// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Selector

This block holds the occupancy and status logic for a buffered SPI port. It follows a transmit queue and a receive queue, each four words deep, plus a one-word shift register. The serial shifter sends it event strobes: a word was received, or the last bit of a word was sent. The register interface sends two more: a CPU write into the transmit queue and a CPU read from the receive queue. The block works out the occupancy counts, the empty and full flags and a sticky overflow, and packs them into a 16-bit status word.

A word moves from the transmit queue into the shift register on its own whenever the shift register is free. A 3-bit mode input selects one of eight interrupt sources. Four of them watch transmit events or levels and four watch receive levels or events. The interrupt is a registered pulse one cycle wide. The block can be switched off, which clears all of its state. It can also be set to freeze while an idle input is high.

Top module: `spi_fifo_stat`

## Requirements
- R1: Status bit 15 reads the enable input, bit 13 the stop-in-idle input and bits 4:2 the interrupt mode input. Bits 14, 12 and 11 read 0.
- R2: While enable is low, all state is cleared on the next clock: counts 0, shift register free, overflow 0, interrupt 0. Status then reads bits 10:8=0, bit7=1, bit6=0, bit5=1, bit1=0, bit0=0.
- R3: While stop-in-idle and idle are both high, every strobe is ignored, all state is held and the interrupt stays low. With stop-in-idle low, idle has no effect.
- R4: A CPU write adds one word to the transmit queue. A write to a full queue (4 words) is dropped, and bit 1 reads 1 at 4 words. When the shift register is free and the queue is not empty, one word moves into the shift register on the next clock. Bit 7 reads 1 while the shift register is free, and the last-bit-out strobe frees it.
- R5: Bits 10:8 give the transmit queue count plus 1 if the shift register is busy when the master input is high. They give the receive queue count when it is low.
- R6: A word-received strobe adds one word to the receive queue and a CPU read removes one. Bit 5 reads 1 when the queue is empty and bit 0 reads 1 when it holds 4. A read of an empty queue leaves the count unchanged.
- R7: A received word that arrives with the receive queue full, and no read in the same cycle, is discarded and sets bit 6. Bit 6 stays set until the overflow-clear input is pulsed. A new overflow in the same cycle as a clear wins.
- R8: A push and a pop on the same queue in the same cycle leave its count unchanged, even when the queue is full.
- R9: Mode 7 fires when the transmit queue becomes full. Mode 6 fires on a received word while the transmit queue is empty. Mode 5 fires on a last-bit-out strobe while the shift register is busy. Mode 4 fires when a word moves into the shift register.
- R10: Mode 3 fires when the receive queue becomes full. Mode 2 fires when it rises to 3 or more. Mode 1 fires when it goes from empty to non-empty. Mode 0 fires when a read leaves it empty.
- R11: The interrupt output is registered. It is high for the one cycle after the clock edge at which its event or level rise is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Block enable; low clears all state |
| stop_idle_i | input | 1 | Freeze while idle is high |
| idle_i | input | 1 | Idle request |
| master_i | input | 1 | Selects the meaning of the count field |
| irq_mode_i | input | 3 | Interrupt source select |
| cpu_wr_i | input | 1 | CPU write strobe into the transmit queue |
| cpu_rd_i | input | 1 | CPU read strobe from the receive queue |
| shift_in_i | input | 1 | Shifter received a complete word |
| shift_out_i | input | 1 | Shifter sent the last bit of a word |
| ovf_clr_i | input | 1 | Software clear of the overflow flag |
| status_o | output | 16 | Packed status word |
| irq_o | output | 1 | Interrupt pulse |

## Verification
Two pairs of functions can fall in the same cycle. A received word can meet a CPU read with the receive queue full. An automatic transfer into the shift register can meet a CPU write with the transmit queue full. The bench sets up both cases on purpose. It first fills a queue to four words. It then fires both strobes together, and in the transmit case it times the write to the cycle in which the shift register was just freed. It judges the result against a behavioural model: the count must stay at 4, no overflow may be raised, and no full-level interrupt may repeat. An overflow coinciding with a software clear is also provoked, and the flag must end up set.

// File: rtl/spi_fifo_stat_pkg.sv
package spi_fifo_stat_pkg;

    typedef enum logic [2:0] {
        IM_RX_DRAINED = 3'd0,
        IM_RX_ANY     = 3'd1,
        IM_RX_3Q      = 3'd2,
        IM_RX_FULL    = 3'd3,
        IM_TX_LOAD    = 3'd4,
        IM_TX_DONE    = 3'd5,
        IM_RX_TXEMPTY = 3'd6,
        IM_TX_FULL    = 3'd7
    } irq_mode_e;

    typedef struct packed {
        logic busy;
        logic ovf;
        logic irq;
    } ctl_s;

endpackage

// File: rtl/spi_fifo_occ.sv
module spi_fifo_occ #(
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          push_req_i,
    input  logic          pop_req_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_next_o,
    output logic          push_ok_o,
    output logic          pop_ok_o
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        pop_ok_o  = pop_req_i && (cnt_q != '0);
        push_ok_o = push_req_i && ((cnt_q != FULL) || pop_ok_o);
        cnt_d     = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (push_ok_o && !pop_ok_o) begin
            cnt_d = cnt_q + CW'(1);
        end else if (pop_ok_o && !push_ok_o) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o      = cnt_q;
    assign cnt_next_o = cnt_d;

endmodule

// File: rtl/spi_irq_sel.sv
module spi_irq_sel
    import spi_fifo_stat_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [2:0]    mode_i,
    input  logic [CW-1:0] tx_cnt_i,
    input  logic [CW-1:0] tx_cnt_next_i,
    input  logic [CW-1:0] rx_cnt_i,
    input  logic [CW-1:0] rx_cnt_next_i,
    input  logic          ev_load_i,
    input  logic          ev_done_i,
    input  logic          ev_rx_txempty_i,
    input  logic          ev_drain_i,
    output logic          fire_o
);
    localparam logic [CW-1:0] FULL  = CW'(DEPTH);
    localparam logic [CW-1:0] THR3Q = CW'((3 * DEPTH + 3) / 4);

    irq_mode_e mode;

    always_comb begin
        mode   = irq_mode_e'(mode_i);
        fire_o = 1'b0;
        unique case (mode)
            IM_TX_FULL:    fire_o = (tx_cnt_next_i == FULL) && (tx_cnt_i != FULL);
            IM_RX_TXEMPTY: fire_o = ev_rx_txempty_i;
            IM_TX_DONE:    fire_o = ev_done_i;
            IM_TX_LOAD:    fire_o = ev_load_i;
            IM_RX_FULL:    fire_o = (rx_cnt_next_i == FULL) && (rx_cnt_i != FULL);
            IM_RX_3Q:      fire_o = (rx_cnt_next_i >= THR3Q) && (rx_cnt_i < THR3Q);
            IM_RX_ANY:     fire_o = (rx_cnt_next_i != '0) && (rx_cnt_i == '0);
            IM_RX_DRAINED: fire_o = ev_drain_i;
            default:       fire_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/spi_fifo_stat.sv
module spi_fifo_stat
    import spi_fifo_stat_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable_i,
    input  logic        stop_idle_i,
    input  logic        idle_i,
    input  logic        master_i,
    input  logic [2:0]  irq_mode_i,
    input  logic        cpu_wr_i,
    input  logic        cpu_rd_i,
    input  logic        shift_in_i,
    input  logic        shift_out_i,
    input  logic        ovf_clr_i,
    output logic [15:0] status_o,
    output logic        irq_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    ctl_s st_d, st_q;

    logic          run, clr, load_req, fire;
    logic [CW-1:0] tx_cnt, tx_nxt, rx_cnt, rx_nxt;
    logic          tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic [2:0]    pend_cnt;

    assign run      = enable_i && !(stop_idle_i && idle_i);
    assign clr      = !enable_i;
    assign load_req = run && !st_q.busy;

    spi_fifo_occ #(.DEPTH(DEPTH), .CW(CW)) tx_occ_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .push_req_i (run && cpu_wr_i),
        .pop_req_i  (load_req),
        .cnt_o      (tx_cnt),
        .cnt_next_o (tx_nxt),
        .push_ok_o  (tx_push_ok),
        .pop_ok_o   (tx_pop_ok)
    );

    spi_fifo_occ #(.DEPTH(DEPTH), .CW(CW)) rx_occ_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .push_req_i (run && shift_in_i),
        .pop_req_i  (run && cpu_rd_i),
        .cnt_o      (rx_cnt),
        .cnt_next_o (rx_nxt),
        .push_ok_o  (rx_push_ok),
        .pop_ok_o   (rx_pop_ok)
    );

    spi_irq_sel #(.DEPTH(DEPTH), .CW(CW)) irq_sel_i (
        .mode_i          (irq_mode_i),
        .tx_cnt_i        (tx_cnt),
        .tx_cnt_next_i   (tx_nxt),
        .rx_cnt_i        (rx_cnt),
        .rx_cnt_next_i   (rx_nxt),
        .ev_load_i       (tx_pop_ok),
        .ev_done_i       (run && shift_out_i && st_q.busy),
        .ev_rx_txempty_i (run && shift_in_i && (tx_cnt == '0)),
        .ev_drain_i      (rx_pop_ok && (rx_nxt == '0)),
        .fire_o          (fire)
    );

    always_comb begin
        st_d = st_q;
        if (!enable_i) begin
            st_d = '0;
        end else if (run) begin
            if (tx_pop_ok)                        st_d.busy = 1'b1;
            else if (shift_out_i)                 st_d.busy = 1'b0;
            if (shift_in_i && !rx_push_ok)        st_d.ovf  = 1'b1;
            else if (ovf_clr_i)                   st_d.ovf  = 1'b0;
            st_d.irq = fire;
        end else begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (master_i) pend_cnt = 3'(tx_cnt) + {2'b00, st_q.busy};
        else          pend_cnt = 3'(rx_cnt);
        status_o = {enable_i, 1'b0, stop_idle_i, 2'b00, pend_cnt,
                    !st_q.busy, st_q.ovf, (rx_cnt == '0), irq_mode_i,
                    (tx_cnt == FULL), (rx_cnt == FULL)};
    end

    assign irq_o = st_q.irq;

    logic unused_ok;
    assign unused_ok = tx_push_ok;

endmodule

// File: rtl/spi_fifo_stat_chk.sv
module spi_fifo_stat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        enable_i,
    input logic        stop_idle_i,
    input logic        idle_i,
    input logic        ovf_clr_i,
    input logic [15:0] status_o,
    input logic        irq_o
);
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[14] == 1'b0) && (status_o[12:11] == 2'b00));

    p_ctrl_echo_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[15] == enable_i) && (status_o[13] == stop_idle_i));

    p_disable_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (status_o[7:5] == 3'b101) && (status_o[1:0] == 2'b00) && !irq_o);

    p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && stop_idle_i && idle_i) |=>
            ($stable(status_o[7:5]) && $stable(status_o[1:0]) && !irq_o));

    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] |-> !status_o[5]);

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[6] && enable_i && !ovf_clr_i) |=> status_o[6]);

endmodule

bind spi_fifo_stat spi_fifo_stat_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable_i),
    .stop_idle_i (stop_idle_i),
    .idle_i      (idle_i),
    .ovf_clr_i   (ovf_clr_i),
    .status_o    (status_o),
    .irq_o       (irq_o)
);

// File: tb/spi_fifo_stat_tb.sv
`timescale 1ns/1ps
module spi_fifo_stat_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, sidl = 1'b0, idle = 1'b0, master = 1'b1;
    logic [2:0]  mode = 3'd0;
    logic        wr = 1'b0, rd = 1'b0, sin = 1'b0, sout = 1'b0, oclr = 1'b0;
    logic [15:0] status;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_tx = 0, m_rx = 0, m_busy = 0, m_ovf = 0, m_irq = 0;

    always #5 clk = ~clk;

    spi_fifo_stat dut_i (
        .clk(clk), .rst_n(rst_n), .enable_i(en), .stop_idle_i(sidl),
        .idle_i(idle), .master_i(master), .irq_mode_i(mode),
        .cpu_wr_i(wr), .cpu_rd_i(rd), .shift_in_i(sin), .shift_out_i(sout),
        .ovf_clr_i(oclr), .status_o(status), .irq_o(irq)
    );

    task automatic model_step();
        bit load, pop_rx, push_rx, push_tx, shout, lost;
        int ntx, nrx;
        if (!rst_n || !en) begin
            m_tx = 0; m_rx = 0; m_busy = 0; m_ovf = 0; m_irq = 0;
        end else if (sidl && idle) begin
            m_irq = 0;
        end else begin
            load    = (m_busy == 0) && (m_tx > 0);
            pop_rx  = rd && (m_rx > 0);
            push_rx = sin && ((m_rx < 4) || pop_rx);
            lost    = sin && !push_rx;
            push_tx = wr && ((m_tx < 4) || load);
            shout   = sout && (m_busy != 0);
            ntx = m_tx + int'(push_tx) - int'(load);
            nrx = m_rx + int'(push_rx) - int'(pop_rx);
            case (mode)
                3'd7: m_irq = int'(ntx == 4 && m_tx != 4);
                3'd6: m_irq = int'(sin && m_tx == 0);
                3'd5: m_irq = int'(shout);
                3'd4: m_irq = int'(load);
                3'd3: m_irq = int'(nrx == 4 && m_rx != 4);
                3'd2: m_irq = int'(nrx >= 3 && m_rx < 3);
                3'd1: m_irq = int'(nrx > 0 && m_rx == 0);
                default: m_irq = int'(pop_rx && nrx == 0);
            endcase
            if (load) m_busy = 1;
            else if (sout) m_busy = 0;
            if (lost) m_ovf = 1;
            else if (oclr) m_ovf = 0;
            m_tx = ntx;
            m_rx = nrx;
        end
    endtask

    function automatic logic [15:0] exp_status();
        int cf;
        cf = master ? (m_tx + m_busy) : m_rx;
        return {en, 1'b0, sidl, 2'b00, 3'(cf), (m_busy == 0), (m_ovf != 0),
                (m_rx == 0), mode, (m_tx == 4), (m_rx == 4)};
    endfunction

    task automatic compare(string tag);
        logic [15:0] es;
        es = exp_status();
        checks++;
        if (status !== es || irq !== (m_irq != 0)) begin
            errors++;
            $display("FAIL %s: status=%h irq=%b expected status=%h irq=%0d",
                     tag, status, irq, es, m_irq);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic pulse(bit w, bit r, bit si, bit so, bit oc, string tag);
        wr = w; rd = r; sin = si; sout = so; oclr = oc;
        step(tag);
        wr = 1'b0; rd = 1'b0; sin = 1'b0; sout = 1'b0; oclr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step("R2 reset state");
        en = 1'b1; sidl = 1'b1; mode = 3'd7;
        step("R1 control echo");
        for (int i = 0; i < 5; i++) pulse(1, 0, 0, 0, 0, "R4 tx fill, R9 mode 7");
        pulse(1, 0, 0, 0, 0, "R4 write to full dropped");
        step("R11 pulse ends");
        mode = 3'd5;
        for (int i = 0; i < 2; i++) begin
            pulse(0, 0, 0, 1, 0, "R9 mode 5 done");
            step("R4 reload into shift register");
        end
        pulse(0, 0, 0, 1, 0, "R9 mode 5 done, not busy");
        mode = 3'd4;
        for (int i = 0; i < 5; i++) begin
            pulse(0, 0, 0, 1, 0, "R9 mode 4 free");
            step("R9 mode 4 load");
        end
        mode = 3'd6;
        pulse(0, 0, 1, 0, 0, "R9 mode 6 rx with tx empty");
        pulse(1, 0, 0, 0, 0, "R4 write");
        pulse(0, 0, 1, 0, 0, "R9 mode 6 tx not empty");
        master = 1'b0;
        step("R5 slave count");
        master = 1'b1;
        step("R5 master count");
        mode = 3'd0;
        pulse(0, 1, 0, 0, 0, "R10 mode 0 read");
        pulse(0, 1, 0, 0, 0, "R10 mode 0 last read");
        pulse(0, 1, 0, 0, 0, "R6 read of empty");
        mode = 3'd1;
        pulse(0, 0, 1, 0, 0, "R10 mode 1 any");
        mode = 3'd2;
        pulse(0, 0, 1, 0, 0, "R10 mode 2 below");
        pulse(0, 0, 1, 0, 0, "R10 mode 2 three quarters");
        mode = 3'd3;
        pulse(0, 0, 1, 0, 0, "R10 mode 3 full, R6 full flag");
        pulse(0, 0, 1, 0, 0, "R7 overflow");
        step("R7 sticky");
        pulse(0, 1, 1, 0, 0, "R8 rx push and pop at full");
        pulse(0, 0, 0, 0, 1, "R7 software clear");
        pulse(0, 0, 1, 0, 1, "R7 set wins over clear");
        pulse(0, 0, 0, 0, 1, "R7 clear again");
        mode = 3'd7;
        for (int i = 0; i < 5; i++) pulse(1, 0, 0, 0, 0, "R4 refill tx");
        pulse(0, 0, 0, 1, 0, "R8 free shift register");
        pulse(1, 0, 0, 0, 0, "R8 tx write with load at full");
        step("R8 tx settle");
        idle = 1'b1;
        pulse(0, 1, 0, 0, 0, "R3 halted read");
        pulse(0, 0, 1, 0, 0, "R3 halted shift in");
        pulse(0, 0, 0, 1, 0, "R3 halted shift out");
        pulse(0, 0, 0, 0, 1, "R3 halted clear");
        sidl = 1'b0;
        pulse(0, 1, 0, 0, 0, "R3 idle without stop runs");
        pulse(0, 0, 0, 1, 0, "R3 idle without stop runs");
        step("R3 reload");
        idle = 1'b0;
        en = 1'b0;
        step("R2 disable clears");
        step("R2 disabled hold");
        en = 1'b1;
        step("R1 re-enable");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule